// File: doc/BRIEF.md
# Hybrid Exp-Golomb / Fixed-Length Code Unit

This block converts between small unsigned integers and a compact prefix code used on intermediate streams that carry transform coefficients and motion vectors. Very small values receive short codes of the exp-Golomb kind. Every value from seven upward takes a three-zero escape followed by a fixed six-bit field. This caps the longest codeword at nine bits and keeps both directions of the code to a few levels of logic.

Each request selects an operation. An encode request carries an unsigned value and returns a codeword left-aligned in a nine-bit field, together with its length. A decode request carries a nine-bit window, most significant bit first, and returns the value and the number of bits consumed. An external shifter can advance its stream pointer by that count. The conversion is a single combinational path. It is registered once behind a valid/ready handshake, so each accepted request yields one result on the cycle after acceptance.

Top module: `hvlc_codec`

## Requirements
- R1: Encoding value 0 gives codeword `1` (outCode = 9'b100000000) with outLen = 1.
- R2: Encoding 1 gives `010` and encoding 2 gives `011`, left-aligned, with outLen = 3.
- R3: Encoding a value v from 3 to 6 gives `001` followed by the 2-bit suffix v-3, left-aligned, with outLen = 5.
- R4: Encoding a value v from 7 to 63 gives `000` followed by v as a 6-bit field (outCode = {3'b000, v[5:0]}) with outLen = 9.
- R5: Encoding a value above 63 sets outOverflow = 1 with outCode = 0 and outLen = 0.
- R6: Decoding a window (bit 8 read first) returns the value and length of the leading codeword under the table of R1 to R4, with outInvalid = 0 for canonical codes. Bits after the codeword have no effect.
- R7: Decoding a window `000` + f with a 6-bit field f below 7 returns value f, length 9, and outInvalid = 1.
- R8: Decoding the encoder's codeword for any value 0 to 63 returns that value and the same length.
- R9: inReady = !outValid || outReady. While outValid is high and outReady is low, outValid stays high and every result field holds its value.
- R10: After reset, outValid is 0 and all result fields are 0.
- R11: A request accepted at a clock edge (inValid and inReady both high) appears with outValid = 1 right after that edge.
- R12: Fields that do not belong to the operation read zero: outValue and outInvalid on an encode, and outCode and outOverflow on a decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| inDecode | input | 1 | 1 = decode the window, 0 = encode the value |
| inValue | input | 8 | Value to encode |
| inWindow | input | 9 | Bit window to decode, bit 8 first |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outCode | output | 9 | Left-aligned codeword (encode) |
| outLen | output | 4 | Codeword length in bits |
| outValue | output | 8 | Decoded value (decode) |
| outOverflow | output | 1 | Encode value out of range |
| outInvalid | output | 1 | Decoded escape code was not canonical |

## Verification
The hardest case to reach from the ports is a non-canonical escape: a decode window must hold three leading zeros and a field below seven. Uniformly random windows produce this about once in seventy draws, so the stimulus adds every such window directly. A stalled result must be held while a second request waits at the input. The bench reaches this by dropping outReady with a request queued and checking that the held fields and inReady stay put for several cycles. It then checks that the queued request is taken once the stall ends.

// File: rtl/hvlc_pkg.sv
package hvlc_pkg;
  localparam int PFX_W = 3;       // escape prefix width
  localparam int ESC_MIN = 7;     // first value that uses the escape

  typedef struct packed {
    logic load;    // capture a new result
    logic decode;  // operation of the captured request
  } hvlcStrobe_t;
endpackage

// File: rtl/hvlc_ctrl.sv
module hvlc_ctrl
  import hvlc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inDecode,
  output logic        inReady,
  input  logic        outReady,
  output logic        outValid,
  output hvlcStrobe_t strobe
);
  logic validQ;

  assign inReady = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign strobe.decode = inDecode;
  assign outValid = validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (outReady) validQ <= 1'b0;
  end

  // R11: an accepted request shows up after one edge
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);
  // R9: a stalled result is not dropped
  a_r9_keep_valid: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/hvlc_datapath.sv
module hvlc_datapath
  import hvlc_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int FIX_W = 6,
  localparam int CODE_W = PFX_W + FIX_W,
  localparam int LEN_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  hvlcStrobe_t       strobe,
  input  logic [VAL_W-1:0]  inValue,
  input  logic [CODE_W-1:0] inWindow,
  output logic [CODE_W-1:0] outCode,
  output logic [LEN_W-1:0]  outLen,
  output logic [VAL_W-1:0]  outValue,
  output logic              outOverflow,
  output logic              outInvalid
);
  logic              tooBig;
  logic [FIX_W-1:0]  fixField;
  logic [CODE_W-1:0] encCode;
  logic [LEN_W-1:0]  encLen;
  logic [1:0]        encSfx;
  logic [VAL_W-1:0]  decValue;
  logic [LEN_W-1:0]  decLen;
  logic              decBad;

  generate
    if (VAL_W > FIX_W) begin : g_wide
      assign tooBig = |inValue[VAL_W-1:FIX_W];
      assign fixField = inValue[FIX_W-1:0];
    end else begin : g_narrow
      assign tooBig = 1'b0;
      assign fixField = FIX_W'(inValue);
    end
  endgenerate

  assign encSfx = 2'(inValue - VAL_W'(3));

  // encoder
  always_comb begin
    encCode = '0;
    encLen = '0;
    if (tooBig) begin
      encCode = '0;
    end else if (inValue == '0) begin
      encCode[CODE_W-1] = 1'b1;
      encLen = LEN_W'(1);
    end else if (inValue < VAL_W'(3)) begin
      encCode[CODE_W-1 -: 3] = {2'b01, inValue[1]};
      encLen = LEN_W'(3);
    end else if (inValue < VAL_W'(ESC_MIN)) begin
      encCode[CODE_W-1 -: 5] = {3'b001, encSfx};
      encLen = LEN_W'(5);
    end else begin
      encCode = {{PFX_W{1'b0}}, fixField};
      encLen = LEN_W'(CODE_W);
    end
  end

  // decoder
  always_comb begin
    decBad = 1'b0;
    if (inWindow[CODE_W-1]) begin
      decValue = '0;
      decLen = LEN_W'(1);
    end else if (inWindow[CODE_W-2]) begin
      decValue = VAL_W'(1) + VAL_W'(inWindow[CODE_W-3]);
      decLen = LEN_W'(3);
    end else if (inWindow[CODE_W-3]) begin
      decValue = VAL_W'(3) + VAL_W'(inWindow[CODE_W-4 -: 2]);
      decLen = LEN_W'(5);
    end else begin
      decValue = VAL_W'(inWindow[FIX_W-1:0]);
      decLen = LEN_W'(CODE_W);
      decBad = inWindow[FIX_W-1:0] < FIX_W'(ESC_MIN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outCode <= '0;
      outLen <= '0;
      outValue <= '0;
      outOverflow <= 1'b0;
      outInvalid <= 1'b0;
    end else if (strobe.load) begin
      outCode <= strobe.decode ? '0 : encCode;
      outLen <= strobe.decode ? decLen : encLen;
      outValue <= strobe.decode ? decValue : '0;
      outOverflow <= strobe.decode ? 1'b0 : tooBig;
      outInvalid <= strobe.decode ? decBad : 1'b0;
    end
  end

  // R5: an overflow result carries no codeword
  a_r5_no_code: assert property (@(posedge clk) disable iff (rst)
    outOverflow |-> (outLen == '0 && outCode == '0));
  // R7: only a full escape code can be flagged
  a_r7_invalid_escape: assert property (@(posedge clk) disable iff (rst)
    outInvalid |-> (outLen == LEN_W'(CODE_W) && outValue < VAL_W'(ESC_MIN)));
  // R4: lengths stay within the code's set
  a_r4_len_set: assert property (@(posedge clk) disable iff (rst)
    (outLen == '0 || outLen == LEN_W'(1) || outLen == LEN_W'(3) ||
     outLen == LEN_W'(5) || outLen == LEN_W'(CODE_W)));
  // R12: flags of the two operations never coexist
  a_r12_flags: assert property (@(posedge clk) disable iff (rst)
    !(outOverflow && outInvalid));
endmodule

// File: rtl/hvlc_codec.sv
module hvlc_codec
  import hvlc_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int FIX_W = 6,
  localparam int CODE_W = PFX_W + FIX_W,
  localparam int LEN_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inDecode,
  input  logic [VAL_W-1:0]  inValue,
  input  logic [CODE_W-1:0] inWindow,
  output logic              outValid,
  input  logic              outReady,
  output logic [CODE_W-1:0] outCode,
  output logic [LEN_W-1:0]  outLen,
  output logic [VAL_W-1:0]  outValue,
  output logic              outOverflow,
  output logic              outInvalid
);
  hvlcStrobe_t strobe;

  hvlc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inDecode(inDecode),
    .inReady(inReady), .outReady(outReady), .outValid(outValid),
    .strobe(strobe)
  );

  hvlc_datapath #(.VAL_W(VAL_W), .FIX_W(FIX_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inValue(inValue),
    .inWindow(inWindow), .outCode(outCode), .outLen(outLen),
    .outValue(outValue), .outOverflow(outOverflow), .outInvalid(outInvalid)
  );

  // R9: held result does not change during a stall
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> ($stable(outCode) && $stable(outLen) &&
      $stable(outValue) && $stable(outOverflow) && $stable(outInvalid)));
endmodule

// File: tb/hvlc_codec_tb.sv
module hvlc_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inReady, inDecode = 1'b0;
  logic [7:0] inValue = '0;
  logic [8:0] inWindow = '0;
  logic outValid, outReady = 1'b1;
  logic [8:0] outCode;
  logic [3:0] outLen;
  logic [7:0] outValue;
  logic outOverflow, outInvalid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  hvlc_codec u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inDecode(inDecode), .inValue(inValue), .inWindow(inWindow),
    .outValid(outValid), .outReady(outReady), .outCode(outCode),
    .outLen(outLen), .outValue(outValue), .outOverflow(outOverflow),
    .outInvalid(outInvalid)
  );

  function automatic void expEnc(input int v, output logic [8:0] c,
                                 output logic [3:0] l, output logic o);
    c = '0; l = '0; o = 1'b0;
    if (v > 63) o = 1'b1;
    else if (v == 0) begin c = 9'b100000000; l = 1; end
    else if (v <= 2) begin c = (v == 1) ? 9'b010000000 : 9'b011000000; l = 3; end
    else if (v <= 6) begin c = {3'b001, 2'(v - 3), 4'b0000}; l = 5; end
    else begin c = {3'b000, 6'(v)}; l = 9; end
  endfunction

  function automatic void expDec(input logic [8:0] w, output int v,
                                 output logic [3:0] l, output logic bad);
    bad = 1'b0;
    if (w[8]) begin v = 0; l = 1; end
    else if (w[7]) begin v = 1 + int'(w[6]); l = 3; end
    else if (w[6]) begin v = 3 + int'(w[5:4]); l = 5; end
    else begin v = int'(w[5:0]); l = 9; bad = (v < 7); end
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one request with outReady high, sample result at next negedge
  task automatic issue(input bit dec, input int v, input logic [8:0] w);
    @(negedge clk);
    inValid = 1'b1; inDecode = dec; inValue = 8'(v); inWindow = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runEnc(input string req, input int v);
    logic [8:0] c; logic [3:0] l; logic o;
    expEnc(v, c, l, o);
    issue(1'b0, v, '0);
    check("R11", outValid == 1'b1, "outValid", outValid, 1);
    check(req, outCode == c, "code", outCode, c);
    check(req, outLen == l, "len", outLen, l);
    check(req, outOverflow == o, "overflow", outOverflow, o);
    check("R12", outValue == 0 && !outInvalid, "enc unused", outValue, 0);
  endtask

  task automatic runDec(input string req, input logic [8:0] w);
    int v; logic [3:0] l; logic b;
    expDec(w, v, l, b);
    issue(1'b1, 0, w);
    check("R11", outValid == 1'b1, "outValid", outValid, 1);
    check(req, outValue == 8'(v), "value", outValue, v);
    check(req, outLen == l, "len", outLen, l);
    check(req, outInvalid == b, "invalid", outInvalid, b);
    check("R12", outCode == 0 && !outOverflow, "dec unused", outCode, 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    logic [8:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", outValid == 0 && outCode == 0 && outLen == 0 && outValue == 0
          && !outOverflow && !outInvalid, "reset outputs", outLen, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", outValid == 0, "idle outValid", outValid, 0);

    // directed encodes
    runEnc("R1", 0);
    runEnc("R2", 1);
    runEnc("R2", 2);
    for (int v = 3; v <= 6; v++) runEnc("R3", v);
    runEnc("R4", 7);
    runEnc("R4", 8);
    runEnc("R4", 63);
    runEnc("R5", 64);
    runEnc("R5", 255);

    // R6 trailing bits ignored
    runDec("R6", 9'b1_11111111);
    runDec("R6", 9'b010_111111);
    runDec("R6", 9'b011_101010);
    runDec("R6", 9'b00110_1111);
    runDec("R6", 9'b000_111111);
    // R7 every non-canonical escape
    for (int f = 0; f < 7; f++) runDec("R7", {3'b000, 6'(f)});

    // R8 round trip
    for (int v = 0; v <= 63; v++) begin
      logic [8:0] c; logic [3:0] l;
      issue(1'b0, v, '0);
      c = outCode; l = outLen;
      issue(1'b1, 0, c | ({9{1'b1}} >> l));  // fill trailing bits with ones
      check("R8", outValue == 8'(v), "roundtrip value", outValue, v);
      check("R8", outLen == l, "roundtrip len", outLen, l);
      check("R8", !outInvalid, "roundtrip invalid", outInvalid, 0);
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2) runEnc("R4", int'($urandom % 80));
      else runDec("R6", 9'($urandom));
    end

    // R9 backpressure
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b1; inDecode = 1'b0; inValue = 8'd5; inWindow = '0;
    @(negedge clk);
    held = outCode;
    check("R9", outValid == 1 && held == 9'b00110_0000, "stalled code", held, 9'b001100000);
    inValue = 8'd40;  // second request waits
    for (int k = 0; k < 3; k++) begin
      check("R9", inReady == 0, "inReady stalled", inReady, 0);
      @(negedge clk);
      check("R9", outValid == 1 && outCode == held && outLen == 4'd5,
            "held code", outCode, held);
    end
    check("R9", inReady == 0, "inReady before release", inReady, 0);
    outReady = 1'b1;
    #1;
    check("R9", inReady == 1, "inReady on release", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    check("R9", outValid == 1 && outCode == {3'b000, 6'd40} && outLen == 4'd9,
          "queued result", outCode, {3'b000, 6'd40});
    @(negedge clk);
    check("R9", outValid == 0, "drained", outValid, 0);

    finishRun();
  end
endmodule